// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache

This block is a byte-wide data cache placed between a processor load/store port and a slower backing memory. Each request carries an address, which the cache cuts into a byte offset within the line, a set index and a tag. The tags of every way in the indexed set are compared at once. A hit is served from the cached copy. A miss fetches the whole line from memory one byte per handshake beat before the request is served.

Stores use write-allocate and write-back. A store hit changes only the cached byte and marks the line dirty. A store miss first fetches the line, then writes the byte, so the line ends dirty. When a line must be replaced, the cache takes the lowest-numbered empty way. If no way is empty, it takes the way that has gone longest without an access, where both hits and fills count as accesses. A dirty victim is copied back to memory before the refill starts. Each completed access raises exactly one hit or miss strobe for one cycle, so the hit ratio can be counted outside the block.

The geometry is set by parameters: WAYS, LINES and LINE_BYTES, which must be powers of two with at least two sets and at least two bytes per line. The default is 2 ways, 8 lines and 2-byte lines on an 8-bit address.

Top module: `sa_wb_cache`

## Requirements
- R1: After a synchronous reset, no line is valid. `cpu_ready` is 1, `cpu_hit`, `cpu_miss` and `mem_req` are 0, and the first access to any address is a miss.
- R2: The offset is the low log2(LINE_BYTES) address bits. The set index is the next log2(LINES/WAYS) bits, and the tag is the remaining upper bits. The default split is a 1-bit offset, a 2-bit set index in bits 2:1 and a 5-bit tag in bits 7:3. Two addresses that differ only in the offset share a line.
- R3: A request is accepted on a rising edge where `cpu_req` and `cpu_ready` are both 1. If the request hits, `cpu_hit` is 1 in the following cycle, and for a load `cpu_rdata` holds the cached byte in that same cycle. A hit causes no memory transfer and leaves `cpu_ready` at 1, so requests can follow back to back.
- R4: A store hit writes the byte into the cache only and marks the line dirty. It makes no memory write. A later load of that byte returns the stored value.
- R5: On a miss, `cpu_ready` stays 0 until the access completes. Memory beats follow a `mem_req`/`mem_ack` handshake: a beat completes on an edge where both are 1, and address and direction hold until then. The refill reads LINE_BYTES beats at the line's addresses in rising offset order. The cycle after `mem_req` falls, `cpu_miss` pulses and a load's byte appears on `cpu_rdata`.
- R6: A store miss refills the line exactly as a load miss does, then writes the byte and leaves the line dirty.
- R7: A miss to a set that still has an invalid way fills the lowest-numbered invalid way. No resident line is evicted and no write-back occurs.
- R8: When all ways of the set are valid, the victim is the way with the oldest access, where both hits and fills count as accesses.
- R9: A dirty victim is written to memory at its own addresses in LINE_BYTES write beats (`mem_we` = 1) before the refill reads begin. A clean victim is not written.
- R10: A line refilled for a load is clean: evicting it later, without a store in between, causes no write-back.
- R11: In the default configuration, the sequence load 44, load 68, store 45, store 8, load 12 yields miss, miss, hit, miss, miss. The last access evicts the clean line holding 68, so a following load of 68 misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store byte |
| cpu_ready | output | 1 | Cache can accept a request |
| cpu_rdata | output | DATA_W | Load result, valid with the strobe |
| cpu_hit | output | 1 | One-cycle strobe: access completed as a hit |
| cpu_miss | output | 1 | One-cycle strobe: access completed as a miss |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write-back beat, 0 = refill beat |
| mem_addr | output | ADDR_W | Beat byte address |
| mem_wdata | output | DATA_W | Write-back byte |
| mem_rdata | input | DATA_W | Refill byte, taken when mem_ack is 1 |
| mem_ack | input | 1 | Completes the current beat |

## Verification
Two pieces of work can fall in the same cycle. A hit's strobe and its registered load result leave the block in the same cycle in which the next request is accepted. That next request may be a store writing the very byte just read. The bench provokes this by driving requests with no idle cycle between them, mixing stores and loads to the same line. A reference model updated at each acceptance predicts every strobe, load byte, beat count and the full backing-memory image. A dirty eviction also shares one miss with its refill: the bench counts write and read beats separately and checks the memory image after each access to confirm that the write-back comes first and lands at the victim's address.

// File: rtl/sac_pkg.sv
package sac_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2,
        ST_RESP  = 2'd3
    } sac_state_e;

endpackage

// File: rtl/sac_tag_store.sv
module sac_tag_store #(
    parameter int WAYS  = 2,
    parameter int SETS  = 4,
    parameter int TAG_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(SETS)-1:0]  lk_idx,
    input  logic [TAG_W-1:0]         lk_tag,
    output logic [WAYS-1:0]          set_valid,
    output logic [WAYS-1:0]          set_dirty,
    output logic [WAYS*TAG_W-1:0]    set_tags,
    output logic                     hit,
    output logic [((WAYS>1)?$clog2(WAYS):1)-1:0] hit_way,
    input  logic                     inst_en,
    input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] inst_way,
    input  logic [TAG_W-1:0]         inst_tag,
    input  logic                     dirty_en,
    input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] dirty_way
);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic [TAG_W-1:0] tag_q   [SETS][WAYS];
    logic [TAG_W-1:0] tag_d   [SETS][WAYS];
    logic [WAYS-1:0]  valid_q [SETS];
    logic [WAYS-1:0]  valid_d [SETS];
    logic [WAYS-1:0]  dirty_q [SETS];
    logic [WAYS-1:0]  dirty_d [SETS];
    logic [WAYS-1:0]  match;

    assign set_valid = valid_q[lk_idx];
    assign set_dirty = dirty_q[lk_idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign set_tags[w*TAG_W +: TAG_W] = tag_q[lk_idx][w];
        assign match[w] = valid_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    always_comb begin
        tag_d   = tag_q;
        valid_d = valid_q;
        dirty_d = dirty_q;
        if (inst_en) begin
            tag_d[lk_idx][inst_way]   = inst_tag;
            valid_d[lk_idx][inst_way] = 1'b1;
            dirty_d[lk_idx][inst_way] = 1'b0;
        end
        if (dirty_en) begin
            dirty_d[lk_idx][dirty_way] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            dirty_q <= dirty_d;
        end
        tag_q <= tag_d;
    end

endmodule

// File: rtl/sac_repl.sv
module sac_repl #(
    parameter int WAYS = 2,
    parameter int SETS = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(SETS)-1:0] lk_idx,
    input  logic [WAYS-1:0]         set_valid,
    input  logic                    touch_en,
    input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] touch_way,
    output logic [((WAYS>1)?$clog2(WAYS):1)-1:0] victim_way
);
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    logic             free_found;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] lru_way;

    always_comb begin
        free_found = 1'b0;
        free_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!set_valid[w] && !free_found) begin
                free_found = 1'b1;
                free_way   = WAY_W'(w);
            end
        end
        victim_way = free_found ? free_way : lru_way;
    end

    if (WAYS == 1) begin : g_direct
        logic unused_touch;
        assign unused_touch = ^{clk, rst, touch_en, touch_way, lk_idx};
        assign lru_way      = '0;
    end else if (WAYS == 2) begin : g_pair
        logic [SETS-1:0] lru_q, lru_d;
        always_comb begin
            lru_d = lru_q;
            if (touch_en) lru_d[lk_idx] = ~touch_way[0];
        end
        assign lru_way = lru_q[lk_idx];
        always_ff @(posedge clk) begin
            if (rst) lru_q <= '0;
            else     lru_q <= lru_d;
        end
    end else begin : g_age
        logic [WAY_W-1:0] age_q [SETS][WAYS];
        logic [WAY_W-1:0] age_d [SETS][WAYS];
        logic [WAY_W-1:0] oldest;
        always_comb begin
            age_d = age_q;
            if (touch_en) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (age_q[lk_idx][w] < age_q[lk_idx][touch_way])
                        age_d[lk_idx][w] = age_q[lk_idx][w] + 1'b1;
                end
                age_d[lk_idx][touch_way] = '0;
            end
            oldest = '0;
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[lk_idx][w] == WAY_W'(WAYS - 1)) oldest = WAY_W'(w);
            end
        end
        assign lru_way = oldest;
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SETS; s++)
                    for (int w = 0; w < WAYS; w++)
                        age_q[s][w] <= WAY_W'(w);
            end else begin
                age_q <= age_d;
            end
        end
    end

endmodule

// File: rtl/sac_data_store.sv
module sac_data_store #(
    parameter int WAYS       = 2,
    parameter int SETS       = 4,
    parameter int LINE_BYTES = 2,
    parameter int DATA_W     = 8
) (
    input  logic                          clk,
    input  logic [$clog2(SETS)-1:0]       acc_idx,
    input  logic [((WAYS>1)?$clog2(WAYS):1)-1:0] acc_way,
    input  logic [$clog2(LINE_BYTES)-1:0] acc_off,
    input  logic                          wr_en,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DATA_W-1:0]             rd_data
);
    localparam int DEPTH = SETS * WAYS * LINE_BYTES;

    logic [DATA_W-1:0] byte_q [DEPTH];
    int                slot;

    always_comb begin
        slot    = (int'(acc_idx) * WAYS + int'(acc_way)) * LINE_BYTES + int'(acc_off);
        rd_data = byte_q[slot];
    end

    always_ff @(posedge clk) begin
        if (wr_en) byte_q[slot] <= wr_data;
    end

endmodule

// File: rtl/sa_wb_cache.sv
module sa_wb_cache
    import sac_pkg::*;
#(
    parameter int WAYS       = 2,
    parameter int LINES      = 8,
    parameter int LINE_BYTES = 2,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              cpu_miss,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int SETS  = LINES / WAYS;
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_BYTES - 1);

    typedef struct packed {
        sac_state_e        st;
        logic              pend_we;
        logic [ADDR_W-1:0] pend_addr;
        logic [DATA_W-1:0] pend_wdata;
        logic [WAY_W-1:0]  vict;
        logic [OFF_W-1:0]  beat;
        logic [DATA_W-1:0] rdata;
        logic              hit;
        logic              miss;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [ADDR_W-1:0]     lk_addr;
    logic [OFF_W-1:0]      lk_off;
    logic [IDX_W-1:0]      lk_idx;
    logic [TAG_W-1:0]      lk_tag;
    logic [WAYS-1:0]       set_valid;
    logic [WAYS-1:0]       set_dirty;
    logic [WAYS*TAG_W-1:0] set_tags;
    logic                  tag_hit;
    logic [WAY_W-1:0]      hit_way;
    logic [WAY_W-1:0]      victim_way;
    logic [TAG_W-1:0]      vict_tag;
    logic                  inst_en;
    logic                  dirty_en;
    logic [WAY_W-1:0]      dirty_way;
    logic                  touch_en;
    logic [WAY_W-1:0]      touch_way;
    logic [WAY_W-1:0]      acc_way;
    logic [OFF_W-1:0]      acc_off;
    logic                  dwr_en;
    logic [DATA_W-1:0]     dwr_data;
    logic [DATA_W-1:0]     drd_data;

    assign lk_addr  = (ctl_q.st == ST_IDLE) ? cpu_addr : ctl_q.pend_addr;
    assign lk_off   = lk_addr[OFF_W-1:0];
    assign lk_idx   = lk_addr[OFF_W +: IDX_W];
    assign lk_tag   = lk_addr[ADDR_W-1 -: TAG_W];
    assign vict_tag = set_tags[int'(ctl_q.vict)*TAG_W +: TAG_W];

    sac_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) tags_i (
        .clk       (clk),
        .rst       (rst),
        .lk_idx    (lk_idx),
        .lk_tag    (lk_tag),
        .set_valid (set_valid),
        .set_dirty (set_dirty),
        .set_tags  (set_tags),
        .hit       (tag_hit),
        .hit_way   (hit_way),
        .inst_en   (inst_en),
        .inst_way  (ctl_q.vict),
        .inst_tag  (lk_tag),
        .dirty_en  (dirty_en),
        .dirty_way (dirty_way)
    );

    sac_repl #(.WAYS(WAYS), .SETS(SETS)) repl_i (
        .clk        (clk),
        .rst        (rst),
        .lk_idx     (lk_idx),
        .set_valid  (set_valid),
        .touch_en   (touch_en),
        .touch_way  (touch_way),
        .victim_way (victim_way)
    );

    sac_data_store #(.WAYS(WAYS), .SETS(SETS), .LINE_BYTES(LINE_BYTES), .DATA_W(DATA_W)) data_i (
        .clk     (clk),
        .acc_idx (lk_idx),
        .acc_way (acc_way),
        .acc_off (acc_off),
        .wr_en   (dwr_en),
        .wr_data (dwr_data),
        .rd_data (drd_data)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.hit  = 1'b0;
        ctl_d.miss = 1'b0;
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = {lk_tag, lk_idx, ctl_q.beat};
        mem_wdata  = drd_data;
        inst_en    = 1'b0;
        dirty_en   = 1'b0;
        dirty_way  = ctl_q.vict;
        touch_en   = 1'b0;
        touch_way  = ctl_q.vict;
        acc_way    = ctl_q.vict;
        acc_off    = ctl_q.beat;
        dwr_en     = 1'b0;
        dwr_data   = mem_rdata;

        unique case (ctl_q.st)
            ST_IDLE: begin
                cpu_ready = 1'b1;
                acc_way   = hit_way;
                acc_off   = lk_off;
                dirty_way = hit_way;
                touch_way = hit_way;
                dwr_data  = cpu_wdata;
                if (cpu_req) begin
                    if (tag_hit) begin
                        touch_en  = 1'b1;
                        ctl_d.hit = 1'b1;
                        if (cpu_we) begin
                            dwr_en   = 1'b1;
                            dirty_en = 1'b1;
                        end else begin
                            ctl_d.rdata = drd_data;
                        end
                    end else begin
                        ctl_d.pend_we    = cpu_we;
                        ctl_d.pend_addr  = cpu_addr;
                        ctl_d.pend_wdata = cpu_wdata;
                        ctl_d.vict       = victim_way;
                        ctl_d.beat       = '0;
                        if (set_valid[victim_way] && set_dirty[victim_way])
                            ctl_d.st = ST_WBACK;
                        else
                            ctl_d.st = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = {vict_tag, lk_idx, ctl_q.beat};
                if (mem_ack) begin
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == LAST_BEAT) begin
                        ctl_d.beat = '0;
                        ctl_d.st   = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    dwr_en     = 1'b1;
                    ctl_d.beat = ctl_q.beat + 1'b1;
                    if (ctl_q.beat == LAST_BEAT) begin
                        inst_en    = 1'b1;
                        ctl_d.beat = '0;
                        ctl_d.st   = ST_RESP;
                    end
                end
            end
            ST_RESP: begin
                acc_off    = lk_off;
                dwr_data   = ctl_q.pend_wdata;
                touch_en   = 1'b1;
                ctl_d.miss = 1'b1;
                ctl_d.st   = ST_IDLE;
                if (ctl_q.pend_we) begin
                    dwr_en   = 1'b1;
                    dirty_en = 1'b1;
                end else begin
                    ctl_d.rdata = drd_data;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_rdata = ctl_q.rdata;
    assign cpu_hit   = ctl_q.hit;
    assign cpu_miss  = ctl_q.miss;

endmodule

// File: rtl/sac_checker.sv
module sac_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_ready,
    input logic              cpu_hit,
    input logic              cpu_miss,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr
);

    a_r5_ready_low_in_transfer: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cpu_ready);

    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        !(cpu_hit && cpu_miss));

    a_r3_hit_without_traffic: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |-> !mem_req);

    a_r9_refill_after_writeback: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack) |=> mem_req);

    a_r5_beat_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    a_r5_miss_after_refill: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_req) |=> cpu_miss);

endmodule

bind sa_wb_cache sac_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cpu_ready (cpu_ready),
    .cpu_hit   (cpu_hit),
    .cpu_miss  (cpu_miss),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/sa_wb_cache_tb_top.sv
module sa_wb_cache_tb_top;
    localparam int W    = 2;
    localparam int M    = 8;
    localparam int B    = 2;
    localparam int SETS = M / W;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic       cpu_ready, cpu_hit, cpu_miss;
    logic [7:0] cpu_rdata;
    logic       mem_req, mem_we;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = '0;
    logic       mem_ack = 1'b0;

    always #10 clk = ~clk;

    sa_wb_cache #(.WAYS(W), .LINES(M), .LINE_BYTES(B)) dut_i (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .cpu_hit(cpu_hit), .cpu_miss(cpu_miss), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    typedef struct {
        logic [7:0] addr;
        bit         we;
        logic [7:0] wd;
        int         gap;
        string      tag;
    } op_t;

    typedef struct {
        bit         hit;
        logic [7:0] rd;
        bit         we;
        bit         wb;
        string      tag;
    } exp_t;

    op_t        ops[$];
    exp_t       expq[$];
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];

    int         m_tag [SETS][W];
    bit         m_val [SETS][W];
    bit         m_dty [SETS][W];
    logic [7:0] m_dat [SETS][W][B];
    int         m_use [SETS][W];
    int         tick = 0;

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic push_op(input int a, input bit we, input int wd, input int gap, input string tag);
        op_t o;
        o.addr = 8'(a); o.we = we; o.wd = 8'(wd); o.gap = gap; o.tag = tag;
        ops.push_back(o);
    endtask

    task automatic model_access(input logic [7:0] a, input bit we, input logic [7:0] wd,
                                output bit hit, output logic [7:0] rd, output bit wb);
        int s, t, off, way;
        s   = (int'(a) / B) % SETS;
        t   = int'(a) / (B * SETS);
        off = int'(a) % B;
        way = -1;
        tick++;
        for (int w = 0; w < W; w++) if (m_val[s][w] && m_tag[s][w] == t) way = w;
        hit = (way >= 0);
        wb  = 1'b0;
        if (!hit) begin
            for (int w = 0; w < W; w++) if (!m_val[s][w] && way < 0) way = w;
            if (way < 0) begin
                way = 0;
                for (int w = 1; w < W; w++) if (m_use[s][w] < m_use[s][way]) way = w;
            end
            if (m_val[s][way] && m_dty[s][way]) begin
                wb = 1'b1;
                for (int b = 0; b < B; b++) exp_mem[(m_tag[s][way]*SETS + s)*B + b] = m_dat[s][way][b];
            end
            for (int b = 0; b < B; b++) m_dat[s][way][b] = exp_mem[(t*SETS + s)*B + b];
            m_val[s][way] = 1'b1;
            m_dty[s][way] = 1'b0;
            m_tag[s][way] = t;
        end
        m_use[s][way] = tick;
        if (we) begin
            m_dat[s][way][off] = wd;
            m_dty[s][way] = 1'b1;
            rd = '0;
        end else begin
            rd = m_dat[s][way][off];
        end
    endtask

    initial begin
        int   cyc = 0, op_idx = 0, gap = 0, rd_cnt = 0, wr_cnt = 0, mism;
        bit   drv_valid = 0, ready_seen = 0, miss_out = 0, done = 0;
        op_t  cur;
        exp_t e;
        logic [15:0] lfsr = 16'hACE1;

        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 7 + 3);
            exp_mem[i] = mem[i];
        end
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < W; w++) begin
                m_val[s][w] = 0; m_dty[s][w] = 0; m_use[s][w] = 0; m_tag[s][w] = 0;
            end

        // Example sequence: set 2 sees 44, 68, then 12 evicts 68's line
        push_op(44, 0, 0, 1, "R1/R11");
        push_op(68, 0, 0, 1, "R11");
        push_op(45, 1, 8'h3C, 1, "R11");
        push_op(8, 1, 8'h77, 1, "R11");
        push_op(12, 0, 0, 1, "R11");
        push_op(68, 0, 0, 1, "R11 evicted");
        // Offset shares the line
        push_op(100, 0, 0, 1, "R2");
        push_op(101, 0, 0, 0, "R2");
        push_op(100, 0, 0, 0, "R3");
        push_op(101, 0, 0, 0, "R3");
        push_op(100, 1, 8'hA5, 0, "R4");
        push_op(100, 0, 0, 0, "R4");
        push_op(200, 1, 8'h5E, 1, "R6");
        push_op(200, 0, 0, 0, "R6");
        push_op(201, 0, 0, 0, "R6");
        // Set 1 placement and recency
        push_op(2, 0, 0, 1, "R7");
        push_op(10, 0, 0, 1, "R7");
        push_op(2, 0, 0, 0, "R7");
        push_op(10, 0, 0, 0, "R7");
        push_op(2, 0, 0, 0, "R8");
        push_op(18, 0, 0, 1, "R8");
        push_op(2, 0, 0, 0, "R8");
        push_op(10, 0, 0, 1, "R8");
        push_op(3, 1, 8'hC3, 0, "R9");
        push_op(26, 0, 0, 1, "R9");
        push_op(34, 0, 0, 1, "R9");
        push_op(2, 0, 0, 1, "R9");
        push_op(50, 0, 0, 1, "R10");
        push_op(58, 0, 0, 1, "R10");
        push_op(66, 0, 0, 1, "R10");
        push_op(74, 0, 0, 1, "R10");
        for (int i = 0; i < 300; i++) begin
            int t, s, o;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            t = (int'(lfsr[4:2]) % 5) * 7;
            s = int'(lfsr[6:5]);
            o = int'(lfsr[7]);
            push_op(((t * SETS) + s) * B + o, lfsr[8], int'(lfsr[15:9]), int'(lfsr[9] & lfsr[10]), "R5 mix");
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_ready == 1'b1, "R1", "ready after reset", int'(cpu_ready), 1);
        chk(cpu_hit == 1'b0,   "R1", "hit after reset",   int'(cpu_hit), 0);
        chk(cpu_miss == 1'b0,  "R1", "miss after reset",  int'(cpu_miss), 0);
        chk(mem_req == 1'b0,   "R1", "mem_req after reset", int'(mem_req), 0);
        ready_seen = cpu_ready;

        while (!done) begin
            if (!drv_valid && gap == 0 && op_idx < ops.size()) begin
                cur = ops[op_idx];
                op_idx++;
                gap = cur.gap;
                cpu_req = 1'b1; cpu_we = cur.we; cpu_addr = cur.addr; cpu_wdata = cur.wd;
                drv_valid = 1;
            end else if (!drv_valid) begin
                cpu_req = 1'b0;
                if (gap > 0) gap--;
            end
            ready_seen = cpu_ready;

            @(negedge clk);
            cyc++;

            if (drv_valid && ready_seen) begin
                model_access(cur.addr, cur.we, cur.wd, e.hit, e.rd, e.wb);
                e.we = cur.we; e.tag = cur.tag;
                expq.push_back(e);
                miss_out = !e.hit;
                drv_valid = 0;
                cpu_req = 1'b0;
            end

            if (cpu_hit || cpu_miss) begin
                if (expq.size() == 0) begin
                    chk(0, "R3", "unexpected strobe", 1, 0);
                end else begin
                    e = expq.pop_front();
                    chk(cpu_hit == e.hit && cpu_miss == !e.hit, e.tag, "hit strobe", int'(cpu_hit), int'(e.hit));
                    if (!e.we) chk(cpu_rdata == e.rd, e.tag, "load data", int'(cpu_rdata), int'(e.rd));
                    chk(rd_cnt == (e.hit ? 0 : B), e.tag, "refill beats", rd_cnt, e.hit ? 0 : B);
                    chk(wr_cnt == (e.wb ? B : 0), e.tag, "write-back beats", wr_cnt, e.wb ? B : 0);
                    mism = 0;
                    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) mism++;
                    chk(mism == 0, e.tag, "memory image mismatches", mism, 0);
                end
                rd_cnt = 0; wr_cnt = 0; miss_out = 0;
            end else if (miss_out) begin
                chk(cpu_ready == 1'b0, "R5", "ready during miss", int'(cpu_ready), 0);
            end

            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    wr_cnt++;
                    chk(rd_cnt == 0, "R9", "write-back after refill start", rd_cnt, 0);
                end else begin
                    mem_rdata = mem[mem_addr];
                    rd_cnt++;
                end
                mem_ack = 1'b1;
            end

            if (op_idx >= ops.size() && !drv_valid && gap == 0 && expq.size() == 0 && !miss_out)
                done = 1;
            if (cyc > 100000) begin
                chk(0, "R5", "watchdog expired", cyc, 100000);
                done = 1;
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule